// File: doc/BRIEF.md
# Result Bus Reservation Controller

This block sits at the issue stage of a core whose functional units run in parallel with fixed latencies and share one result bus back to the register file. It keeps a shift register with one stage for each cycle of the longest unit latency. An instruction of latency i books a stage so that its result reaches the bus exactly i cycles after issue. Each stage carries the producing unit, the destination register and the program counter. Each clock every booking moves one stage toward the bus, and the booking in the lowest stage drives the bus select and the register write enable.

When the precise mode input is high, an issuing instruction also fills every free stage below its own with placeholder bookings. A later, shorter instruction therefore cannot overtake an earlier, longer one, and results reach the register file in program order. Stores book a placeholder of their own. When that placeholder reaches the bus stage, the block pulses a release that lets the held store commit to memory.

An exception reported against the booking at the bus stage captures that booking's program counter. It suppresses the booking's own write or release and discards every later booking. Issue then stays blocked until an acknowledge arrives.

Top module: `rbus_resv_ctrl`

## Requirements
- R1: A request granted in cycle c with latency L (1 to MAX_LAT) drives the result bus in cycle c+L. In that cycle bus_vld=1, bus_unit and bus_dst equal the issued values, and bus_wen=1 unless an exception is taken.
- R2: A request is granted only if no booking will occupy stage L in the next cycle. Otherwise iss_stall=1 and the same check repeats every cycle. A latency of 0 or above MAX_LAT is never granted.
- R3: With precise_en=0 only stage L is booked, so a shorter instruction issued after a longer one can reach the bus first.
- R4: Every clock, every booking moves one stage toward the bus stage.
- R5: With precise_en=1 a granted instruction also books every free stage below L with a placeholder. After a 6-cycle issue into an empty register, a 2-cycle request is granted exactly 5 cycles later, and the two results reach the bus on consecutive cycles in issue order.
- R6: A placeholder at the bus stage gives bus_vld=0 and bus_wen=0.
- R7: A store (iss_store=1) writes no register: bus_vld=0 and bus_wen=0. It gives st_release=1 for exactly one cycle, L cycles after its grant.
- R8: exc_flag is taken only when the bus stage holds an instruction or store booking. When taken, pc_saved loads that booking's program counter, its bus_wen and st_release are forced low, all other bookings are discarded, and no grant occurs in that cycle. exc_flag with an empty or placeholder bus stage has no effect.
- R9: After an exception is taken, exc_hold=1, every request stalls, and pc_saved stays constant until exc_ack is sampled high. exc_hold is 0 from the following cycle on.
- R10: During and after reset, no booking exists, exc_hold=0 and pc_saved=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| precise_en | input | 1 | Fill lower free stages with placeholders on issue |
| iss_req | input | 1 | Issue request |
| iss_lat | input | 4 | Latency of the requesting unit (1..MAX_LAT) |
| iss_unit | input | 3 | Functional unit ID |
| iss_dst | input | 5 | Destination register |
| iss_pc | input | 16 | Program counter of the instruction |
| iss_store | input | 1 | Request is a store |
| exc_flag | input | 1 | Exception for the booking at the bus stage |
| exc_ack | input | 1 | Software clears the exception hold |
| iss_grant | output | 1 | Request accepted this cycle |
| iss_stall | output | 1 | Request present but held |
| bus_vld | output | 1 | Result bus carries a register result |
| bus_unit | output | 3 | Unit selected onto the result bus |
| bus_dst | output | 5 | Destination register of the bus result |
| bus_wen | output | 1 | Register file write enable |
| st_release | output | 1 | Held store may commit to memory |
| exc_hold | output | 1 | Exception taken, issue blocked |
| pc_saved | output | 16 | Precise program counter of the exception |

## Verification
The bench times a 2-cycle request behind a 6-cycle one in both modes. A design that checks the wrong stage or skips the placeholder fill grants too early, or lets the short result overtake the long one in precise mode. It also reissues into a stage that frees up one cycle later, to catch a check made against the unshifted view, which would stall one cycle too long. It also raises an exception on the first of two bookings. A design that fails to discard later bookings would still write the second result, and one that captured the program counter at the wrong point would hold the wrong value. An exception flag raised with an empty bus stage must change nothing, which catches a design that halts on any flag.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  typedef enum logic [1:0] {
    K_NULL  = 2'd0,
    K_REG   = 2'd1,
    K_STORE = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/rbus_issue_check.sv
module rbus_issue_check
  import rbus_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N + 1)
) (
  input  logic          req,
  input  logic [LW-1:0] lat,
  input  logic [N-1:0]  busy_next,
  input  logic          halted,
  input  logic          exc_take,
  output logic          grant,
  output logic          stall
);
  logic [N-1:0] lat_hot;
  logic         lat_ok;
  logic         conflict;

  always_comb begin
    lat_hot = '0;
    for (int k = 0; k < N; k++) begin
      if (int'(lat) == k + 1) lat_hot[k] = 1'b1;
    end
  end

  assign lat_ok   = |lat_hot;
  assign conflict = |(busy_next & lat_hot);
  assign grant    = req && lat_ok && !conflict && !halted && !exc_take;
  assign stall    = req && !grant;
endmodule

// File: rtl/rbus_stage_array.sv
module rbus_stage_array
  import rbus_pkg::*;
#(
  parameter int N  = 8,
  parameter int UW = 3,
  parameter int RW = 5,
  parameter int PW = 16,
  parameter int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_lat,
  input  slot_kind_e    wr_kind,
  input  logic [UW-1:0] wr_unit,
  input  logic [RW-1:0] wr_dst,
  input  logic [PW-1:0] wr_pc,
  input  logic          fill_nulls,
  input  logic          flush,
  output logic [N-1:0]  busy_next,
  output logic          s1_vld,
  output slot_kind_e    s1_kind,
  output logic [UW-1:0] s1_unit,
  output logic [RW-1:0] s1_dst,
  output logic [PW-1:0] s1_pc
);
  logic [N-1:0]  v_q, v_d, sh_v;
  slot_kind_e    k_q [N];
  slot_kind_e    k_d [N];
  slot_kind_e    sh_k [N];
  logic [UW-1:0] u_q [N];
  logic [UW-1:0] u_d [N];
  logic [UW-1:0] sh_u [N];
  logic [RW-1:0] d_q [N];
  logic [RW-1:0] d_d [N];
  logic [RW-1:0] sh_d [N];
  logic [PW-1:0] p_q [N];
  logic [PW-1:0] p_d [N];
  logic [PW-1:0] sh_p [N];
  logic [N-1:0]  lat_hot, lat_below;

  // view of the array after one shift toward stage 1
  for (genvar g = 0; g < N; g++) begin : g_shift
    if (g == N - 1) begin : g_top
      assign sh_v[g] = 1'b0;
      assign sh_k[g] = K_NULL;
      assign sh_u[g] = '0;
      assign sh_d[g] = '0;
      assign sh_p[g] = '0;
    end else begin : g_mid
      assign sh_v[g] = v_q[g+1];
      assign sh_k[g] = k_q[g+1];
      assign sh_u[g] = u_q[g+1];
      assign sh_d[g] = d_q[g+1];
      assign sh_p[g] = p_q[g+1];
    end
  end

  always_comb begin
    lat_hot = '0;
    for (int k = 0; k < N; k++) begin
      if (int'(wr_lat) == k + 1) lat_hot[k] = 1'b1;
    end
  end
  assign lat_below = lat_hot - N'(1);
  assign busy_next = sh_v;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      v_d[k] = sh_v[k];
      k_d[k] = sh_k[k];
      u_d[k] = sh_u[k];
      d_d[k] = sh_d[k];
      p_d[k] = sh_p[k];
      if (flush) begin
        v_d[k] = 1'b0;
        k_d[k] = K_NULL;
        u_d[k] = '0;
        d_d[k] = '0;
        p_d[k] = '0;
      end else if (wr_en && lat_hot[k]) begin
        v_d[k] = 1'b1;
        k_d[k] = wr_kind;
        u_d[k] = wr_unit;
        d_d[k] = wr_dst;
        p_d[k] = wr_pc;
      end else if (wr_en && fill_nulls && lat_below[k] && !sh_v[k]) begin
        v_d[k] = 1'b1;
        k_d[k] = K_NULL;
        u_d[k] = '0;
        d_d[k] = '0;
        p_d[k] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < N; k++) begin
        k_q[k] <= K_NULL;
        u_q[k] <= '0;
        d_q[k] <= '0;
        p_q[k] <= '0;
      end
    end else begin
      v_q <= v_d;
      for (int k = 0; k < N; k++) begin
        k_q[k] <= k_d[k];
        u_q[k] <= u_d[k];
        d_q[k] <= d_d[k];
        p_q[k] <= p_d[k];
      end
    end
  end

  assign s1_vld  = v_q[0];
  assign s1_kind = k_q[0];
  assign s1_unit = u_q[0];
  assign s1_dst  = d_q[0];
  assign s1_pc   = p_q[0];

  // R1: a granted booking is present at its stage on the next cycle
  a_r1_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> |(v_q & $past(lat_hot)));

  // R4: without issue or flush, stage 1 takes over stage 2
  a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flush) |=> (v_q[0] == $past(v_q[1]) && p_q[0] == $past(p_q[1])));

  // R5: a precise issue of latency above 1 leaves stage 1 booked
  a_r5_null_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill_nulls && !flush && !lat_hot[0]) |=> v_q[0]);
endmodule

// File: rtl/rbus_retire.sv
module rbus_retire
  import rbus_pkg::*;
#(
  parameter int UW = 3,
  parameter int RW = 5,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_vld,
  input  slot_kind_e    s1_kind,
  input  logic [UW-1:0] s1_unit,
  input  logic [RW-1:0] s1_dst,
  input  logic [PW-1:0] s1_pc,
  input  logic          exc_flag,
  input  logic          exc_ack,
  output logic          bus_vld,
  output logic [UW-1:0] bus_unit,
  output logic [RW-1:0] bus_dst,
  output logic          bus_wen,
  output logic          st_release,
  output logic          exc_take,
  output logic          halted,
  output logic [PW-1:0] pc_saved
);
  logic          is_reg, is_store, real_slot;
  logic          halt_d;
  logic          pc_en;
  logic [PW-1:0] pc_d;

  assign is_reg    = s1_vld && (s1_kind == K_REG);
  assign is_store  = s1_vld && (s1_kind == K_STORE);
  assign real_slot = is_reg || is_store;
  assign exc_take  = exc_flag && real_slot && !halted;

  assign bus_vld    = is_reg;
  assign bus_unit   = is_reg ? s1_unit : '0;
  assign bus_dst    = is_reg ? s1_dst : '0;
  assign bus_wen    = is_reg && !exc_take && !halted;
  assign st_release = is_store && !exc_take && !halted;

  always_comb begin
    halt_d = halted;
    if (exc_take)     halt_d = 1'b1;
    else if (exc_ack) halt_d = 1'b0;
    pc_en = exc_take;
    pc_d  = s1_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted   <= 1'b0;
      pc_saved <= '0;
    end else begin
      halted <= halt_d;
      if (pc_en) pc_saved <= pc_d;
    end
  end

  // R8: a taken exception leaves the hold set and the booking's PC saved
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (halted && pc_saved == $past(s1_pc)));

  // R9: nothing commits while held
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!bus_wen && !st_release));

  // R9: saved PC is frozen during the hold
  a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !exc_ack) |=> $stable(pc_saved));
endmodule

// File: rtl/rbus_resv_ctrl.sv
module rbus_resv_ctrl
  import rbus_pkg::*;
#(
  parameter int MAX_LAT = 8,
  parameter int UNIT_W  = 3,
  parameter int DST_W   = 5,
  parameter int PC_W    = 16,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              precise_en,
  input  logic              iss_req,
  input  logic [LAT_W-1:0]  iss_lat,
  input  logic [UNIT_W-1:0] iss_unit,
  input  logic [DST_W-1:0]  iss_dst,
  input  logic [PC_W-1:0]   iss_pc,
  input  logic              iss_store,
  input  logic              exc_flag,
  input  logic              exc_ack,
  output logic              iss_grant,
  output logic              iss_stall,
  output logic              bus_vld,
  output logic [UNIT_W-1:0] bus_unit,
  output logic [DST_W-1:0]  bus_dst,
  output logic              bus_wen,
  output logic              st_release,
  output logic              exc_hold,
  output logic [PC_W-1:0]   pc_saved
);
  logic [MAX_LAT-1:0] busy_next;
  logic               exc_take;
  logic               s1_vld;
  slot_kind_e         s1_kind;
  slot_kind_e         wr_kind;
  logic [UNIT_W-1:0]  s1_unit;
  logic [DST_W-1:0]   s1_dst;
  logic [PC_W-1:0]    s1_pc;

  assign wr_kind = iss_store ? K_STORE : K_REG;

  rbus_issue_check #(.N(MAX_LAT), .LW(LAT_W)) u_check (
    .req       (iss_req),
    .lat       (iss_lat),
    .busy_next (busy_next),
    .halted    (exc_hold),
    .exc_take  (exc_take),
    .grant     (iss_grant),
    .stall     (iss_stall)
  );

  rbus_stage_array #(.N(MAX_LAT), .UW(UNIT_W), .RW(DST_W), .PW(PC_W), .LW(LAT_W)) u_stages (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (iss_grant),
    .wr_lat     (iss_lat),
    .wr_kind    (wr_kind),
    .wr_unit    (iss_unit),
    .wr_dst     (iss_dst),
    .wr_pc      (iss_pc),
    .fill_nulls (precise_en),
    .flush      (exc_take),
    .busy_next  (busy_next),
    .s1_vld     (s1_vld),
    .s1_kind    (s1_kind),
    .s1_unit    (s1_unit),
    .s1_dst     (s1_dst),
    .s1_pc      (s1_pc)
  );

  rbus_retire #(.UW(UNIT_W), .RW(DST_W), .PW(PC_W)) u_retire (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_vld     (s1_vld),
    .s1_kind    (s1_kind),
    .s1_unit    (s1_unit),
    .s1_dst     (s1_dst),
    .s1_pc      (s1_pc),
    .exc_flag   (exc_flag),
    .exc_ack    (exc_ack),
    .bus_vld    (bus_vld),
    .bus_unit   (bus_unit),
    .bus_dst    (bus_dst),
    .bus_wen    (bus_wen),
    .st_release (st_release),
    .exc_take   (exc_take),
    .halted     (exc_hold),
    .pc_saved   (pc_saved)
  );

  // R8: a taken exception empties the bus stage on the next cycle
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !s1_vld);

  // R9: held state never grants
  a_r9_no_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    exc_hold |-> !iss_grant);
endmodule

// File: tb/rbus_resv_ctrl_tb_top.sv
module rbus_resv_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 6;
  // {store, lat[3:0], unit[2:0], dst[4:0], pc[15:0]}
  localparam logic [28:0] TBL [0:NV-1] = '{
    {1'b0, 4'd1, 3'd1, 5'd3,  16'h0100},
    {1'b0, 4'd2, 3'd2, 5'd4,  16'h0104},
    {1'b0, 4'd8, 3'd5, 5'd31, 16'h0108},
    {1'b1, 4'd4, 3'd4, 5'd0,  16'h010C},
    {1'b0, 4'd5, 3'd3, 5'd17, 16'h0110},
    {1'b1, 4'd1, 3'd4, 5'd0,  16'h0114}
  };

  logic        clk, rst_n, precise_en, iss_req, iss_store, exc_flag, exc_ack;
  logic [3:0]  iss_lat;
  logic [2:0]  iss_unit;
  logic [4:0]  iss_dst;
  logic [15:0] iss_pc;
  logic        iss_grant, iss_stall, bus_vld, bus_wen, st_release, exc_hold;
  logic [2:0]  bus_unit;
  logic [4:0]  bus_dst;
  logic [15:0] pc_saved;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int c0;

  rbus_resv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .precise_en(precise_en),
    .iss_req(iss_req), .iss_lat(iss_lat), .iss_unit(iss_unit),
    .iss_dst(iss_dst), .iss_pc(iss_pc), .iss_store(iss_store),
    .exc_flag(exc_flag), .exc_ack(exc_ack),
    .iss_grant(iss_grant), .iss_stall(iss_stall), .bus_vld(bus_vld),
    .bus_unit(bus_unit), .bus_dst(bus_dst), .bus_wen(bus_wen),
    .st_release(st_release), .exc_hold(exc_hold), .pc_saved(pc_saved)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic put(input int lat, input int unit, input int dst, input int pc, input bit st);
    iss_req   = 1'b1;
    iss_lat   = 4'(lat);
    iss_unit  = 3'(unit);
    iss_dst   = 5'(dst);
    iss_pc    = 16'(pc);
    iss_store = st;
  endtask

  initial begin
    #(CLK_P * 5000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; precise_en = 1'b1; iss_req = 1'b0; iss_lat = '0;
    iss_unit = '0; iss_dst = '0; iss_pc = '0; iss_store = 1'b0;
    exc_flag = 1'b0; exc_ack = 1'b0;
    repeat (3) nxt();
    #1;
    chk("R10 hold in reset", exc_hold, 0);
    chk("R10 pc in reset", pc_saved, 0);
    chk("R10 bus_vld in reset", bus_vld, 0);
    nxt(); rst_n = 1'b1;
    nxt(); #1;
    chk("R10 no release after reset", st_release, 0);
    chk("R10 pc after reset", pc_saved, 0);

    // R8: flag with an empty bus stage is ignored
    nxt(); exc_flag = 1'b1; #1;
    nxt(); exc_flag = 1'b0; #1;
    chk("R8 idle flag ignored hold", exc_hold, 0);
    chk("R8 idle flag ignored pc", pc_saved, 0);

    // R1/R7: table of single issues into an empty register
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = TBL[i];
      nxt(); put(int'(v[27:24]), int'(v[23:21]), int'(v[20:16]), int'(v[15:0]), v[28]); #1;
      chk("R1 grant empty", iss_grant, 1);
      c0 = cyc;
      nxt(); iss_req = 1'b0; #1;
      while (!(bus_vld || st_release) && (cyc - c0) < 12) begin
        nxt(); #1;
      end
      chk("R1 arrival cycle", cyc - c0, int'(v[27:24]));
      if (v[28]) begin
        chk("R7 release", st_release, 1);
        chk("R7 no bus", bus_vld, 0);
        chk("R7 no write", bus_wen, 0);
      end else begin
        chk("R1 bus dst", bus_dst, int'(v[20:16]));
        chk("R1 bus unit", bus_unit, int'(v[23:21]));
        chk("R1 write", bus_wen, 1);
      end
      nxt(); #1;
      chk("R7 single pulse", st_release, 0);
      chk("R1 bus idle after", bus_vld, 0);
    end

    // R2: out-of-range latencies
    nxt(); put(0, 1, 1, 0, 1'b0); #1;
    chk("R2 lat0 stall", iss_stall, 1);
    chk("R2 lat0 grant", iss_grant, 0);
    nxt(); iss_lat = 4'd9; #1;
    chk("R2 lat9 grant", iss_grant, 0);
    nxt(); iss_req = 1'b0;

    // R5/R6: precise, 6-cycle then 2-cycle
    nxt(); put(6, 2, 10, 16'h0200, 1'b0); #1;
    chk("R5 first grant", iss_grant, 1);
    c0 = cyc;
    nxt(); put(2, 3, 11, 16'h0204, 1'b0); #1;
    while (!iss_grant && (cyc - c0) < 20) begin
      if (cyc == c0 + 2) begin
        chk("R6 placeholder bus_vld", bus_vld, 0);
        chk("R6 placeholder wen", bus_wen, 0);
      end
      nxt(); #1;
    end
    chk("R5 second grant delay", cyc - c0, 5);
    nxt(); iss_req = 1'b0; #1;
    chk("R5 long first", bus_dst, 10);
    chk("R5 long first vld", bus_vld, 1);
    nxt(); #1;
    chk("R5 short second", bus_dst, 11);
    chk("R5 short second wen", bus_wen, 1);

    // R3/R4: free order
    nxt(); precise_en = 1'b0; put(6, 2, 12, 16'h0300, 1'b0); #1;
    chk("R3 first grant", iss_grant, 1);
    c0 = cyc;
    nxt(); put(2, 3, 13, 16'h0304, 1'b0); #1;
    chk("R3 immediate grant", iss_grant, 1);
    nxt(); iss_req = 1'b0; #1;
    nxt(); #1;
    chk("R3 short overtakes", bus_dst, 13);
    repeat (3) nxt();
    #1;
    chk("R4 long arrives by shifting", bus_dst, 12);
    chk("R4 long arrival cycle", cyc - c0, 6);

    // R2: one-cycle recheck
    nxt(); put(3, 1, 14, 16'h0400, 1'b0); #1;
    chk("R2 base grant", iss_grant, 1);
    c0 = cyc;
    nxt(); put(2, 2, 15, 16'h0404, 1'b0); #1;
    chk("R2 stall on busy stage", iss_stall, 1);
    nxt(); #1;
    chk("R2 grant after recheck", iss_grant, 1);
    nxt(); iss_req = 1'b0; #1;
    chk("R2 first result", bus_dst, 14);
    nxt(); #1;
    chk("R2 second result", bus_dst, 15);

    // R8/R9: exception on first of two bookings
    nxt(); precise_en = 1'b1; put(3, 1, 1, 16'h00A0, 1'b0); #1;
    chk("R8 grant A", iss_grant, 1);
    c0 = cyc;
    nxt(); put(4, 2, 2, 16'h00B0, 1'b0); #1;
    chk("R8 grant B", iss_grant, 1);
    nxt(); iss_req = 1'b0; #1;
    nxt(); exc_flag = 1'b1; #1;
    chk("R8 excepting booking on bus", bus_dst, 1);
    chk("R8 write suppressed", bus_wen, 0);
    chk("R8 no grant in exc cycle", iss_grant, 0);
    nxt(); exc_flag = 1'b0; put(1, 1, 5, 16'h00C0, 1'b0); #1;
    chk("R9 hold set", exc_hold, 1);
    chk("R8 pc captured", pc_saved, 16'h00A0);
    chk("R9 stall while held", iss_stall, 1);
    nxt(); #1;
    chk("R8 later booking cancelled vld", bus_vld, 0);
    chk("R8 later booking cancelled wen", bus_wen, 0);
    nxt(); exc_ack = 1'b1; #1;
    chk("R9 hold until ack sampled", exc_hold, 1);
    nxt(); exc_ack = 1'b0; #1;
    chk("R9 hold cleared", exc_hold, 0);
    chk("R9 grant after clear", iss_grant, 1);
    chk("R9 pc kept", pc_saved, 16'h00A0);
    nxt(); iss_req = 1'b0;
    repeat (3) nxt();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule